// File: doc/BRIEF.md
# Clock-Rate Controller with Receive-Edge Switchback

This block sets the core clock rate of a small microcontroller-style core. Software picks the rate through a two-bit rate field. The two low codes give the normal rate, which is one core cycle in four oscillator cycles. The two high codes give slower power-saving rates. The block does not gate or derive any clock. It emits a one-cycle clock-enable pulse at the selected rate, and the core advances on that pulse.

A switchback circuit returns the core to full speed when serial traffic arrives. Each receive line passes through a two-flop synchronizer, then an edge detector. When switchback is enabled, any falling edge on any receive line forces the rate field back to the normal code at once. The block does not wait to learn whether a real character is arriving. Once the rate field has returned to normal, it stays there until software writes it again.

Each port has its own start-bit checker. An edge on an idle port marks that port active. The checker then samples the line at mid-bit, eight oversample ticks later. A low sample accepts the start bit and produces a one-cycle accept pulse. A high sample rejects the start bit and drops the activity mark. A rejected start bit still leaves the core at full speed. A status vector combines the per-port activity marks with external interrupt-activity flags, so software can see whether it is safe to slow down.

Top module: `crs_clk_rate_ctl`

## Requirements
- R1: While reset is asserted, the rate field reads 00, clk_en_o stays low, start_ok_o is all zero and the activity bits status_o[3:0] are zero.
- R2: A cycle with rate_wr_i high loads rate_sel_i into the rate field, and the new value reads back on rate_sel_o from the next cycle. Codes 00 and 01 select divide-by-4. Code 10 selects divide-by-2^PM1_LOG2 (64 by default). Code 11 selects divide-by-2^PM2_LOG2 (1024 by default).
- R3: clk_en_o is a one-cycle pulse. It repeats once every N clock cycles, where N is the division ratio of the current code, and it is never high in two consecutive cycles.
- R4: While sb_en_i is high, a falling edge on any bit of rx_i sets the rate field to 00. The new value shows on rate_sel_o at most three clock edges after the line drops. The change happens before the start bit is judged, and the clk_en_o period then becomes 4.
- R5: A falling edge on an idle port p sets its activity bit status_o[p], whatever the value of sb_en_i.
- R6: After the edge, the checker counts os_tick_i pulses. On the eighth tick it samples the synchronized line. If the sample is low, start_ok_o[p] pulses for one cycle, and status_o[p] stays set until rx_done_i[p] is pulsed.
- R7: If the mid-bit sample is high, status_o[p] clears and no start_ok_o[p] pulse occurs. A rate field already forced to 00 stays 00.
- R8: After a switchback, the rate field never leaves 00 on its own, however long the block runs. Only a write moves it.
- R9: While sb_en_i is low, receive-line edges leave the rate field unchanged.
- R10: If a write and a switchback edge land on the same cycle, the switchback wins and the field becomes 00.
- R11: status_o[3:0] holds the per-port activity bits (bit p for port p, unused bits zero). status_o[7:4] mirrors irq_act_i.
- R12: A falling edge on a port that is already being checked or is receiving does not start a new check or raise start_ok_o. With sb_en_i high, it still forces the switchback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_wr_i | input | 1 | Write strobe for the rate field |
| rate_sel_i | input | 2 | Rate code to write |
| sb_en_i | input | 1 | Switchback enable |
| rx_i | input | NUM_PORTS | Asynchronous serial receive lines, idle high |
| os_tick_i | input | 1 | Receive oversample tick, 16 per bit time |
| rx_done_i | input | NUM_PORTS | Per-port end-of-character pulse from the receiver |
| irq_act_i | input | 4 | Interrupt-activity flags shown in the status vector |
| rate_sel_o | output | 2 | Current rate field |
| clk_en_o | output | 1 | One-cycle core clock-enable pulse |
| start_ok_o | output | NUM_PORTS | One-cycle pulse per port when its start bit is accepted |
| status_o | output | 8 | Interrupt activity in 7:4, serial activity in 3:0 |

## Verification
The bench targets the cycle in which a write and a synchronized edge collide. A design that gave the write priority would stay in the slow rate while a character was already arriving. The bench also sends a short glitch that fails the mid-bit check and then waits a long time. A design that restored the slow rate on rejection, or that left the activity bit set, would fail there. The remaining cases are an edge arriving while a port is already receiving, which must not count as a second start, and an edge with switchback disabled, which must still mark activity but leave the rate untouched.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam logic [1:0] RATE_NORM = 2'b00;
  localparam logic [1:0] RATE_PM1  = 2'b10;
  localparam logic [1:0] RATE_PM2  = 2'b11;

  localparam int STAT_W   = 8;
  localparam int SER_SLOT = 4;
  localparam int IRQ_W    = 4;

  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_CHECK = 2'd1,
    SC_BUSY  = 2'd2
  } sc_state_e;
endpackage

// File: rtl/crs_rx_edge.sv
module crs_rx_edge #(
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] rx_i,
  output logic [NP-1:0] rx_sync_o,
  output logic [NP-1:0] fall_o
);
  for (genvar p = 0; p < NP; p++) begin : g_port
    logic s1_q, s2_q, prev_q;
    logic s1_d, s2_d, prev_d;

    always_comb begin
      s1_d   = rx_i[p];
      s2_d   = s1_q;
      prev_d = s2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b1;
        s2_q   <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        s1_q   <= s1_d;
        s2_q   <= s2_d;
        prev_q <= prev_d;
      end
    end

    assign rx_sync_o[p] = s2_q;
    assign fall_o[p]    = prev_q & ~s2_q;
  end
endmodule

// File: rtl/crs_start_check.sv
module crs_start_check
  import crs_pkg::*;
#(
  parameter int MID_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic fall_i,
  input  logic rx_i,
  input  logic done_i,
  output logic active_o,
  output logic accept_o
);
  localparam int CW = (MID_TICKS > 2) ? $clog2(MID_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(MID_TICKS - 1);

  sc_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          acc_q, acc_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    acc_d   = 1'b0;
    unique case (state_q)
      SC_IDLE: begin
        if (fall_i) begin
          state_d = SC_CHECK;
          cnt_d   = '0;
        end
      end
      SC_CHECK: begin
        if (tick_i) begin
          if (cnt_q == LAST) begin
            if (rx_i) begin
              state_d = SC_IDLE;
            end else begin
              state_d = SC_BUSY;
              acc_d   = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      SC_BUSY: begin
        if (done_i) state_d = SC_IDLE;
      end
      default: state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      cnt_q   <= '0;
      acc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
    end
  end

  assign active_o = (state_q != SC_IDLE);
  assign accept_o = acc_q;
endmodule

// File: rtl/crs_rate_gen.sv
module crs_rate_gen
  import crs_pkg::*;
#(
  parameter int NORM_LOG2 = 2,
  parameter int PM1_LOG2  = 6,
  parameter int PM2_LOG2  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [1:0] wr_sel_i,
  input  logic       sb_fire_i,
  output logic [1:0] sel_o,
  output logic       ce_o
);
  localparam int CNT_W = PM2_LOG2;
  localparam logic [CNT_W-1:0] LIM_NORM = CNT_W'((1 << NORM_LOG2) - 1);
  localparam logic [CNT_W-1:0] LIM_PM1  = CNT_W'((1 << PM1_LOG2) - 1);
  localparam logic [CNT_W-1:0] LIM_PM2  = CNT_W'((1 << PM2_LOG2) - 1);

  logic [1:0]       sel_q, sel_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim;
  logic             term;

  always_comb begin
    case (sel_q)
      RATE_PM1: lim = LIM_PM1;
      RATE_PM2: lim = LIM_PM2;
      default:  lim = LIM_NORM;
    endcase
    term = (cnt_q == lim);
  end

  // switchback has priority over a software write in the same cycle
  always_comb begin
    sel_d = sel_q;
    if (sb_fire_i)    sel_d = RATE_NORM;
    else if (wr_en_i) sel_d = wr_sel_i;
    cnt_d = (term || (sel_d != sel_q)) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= RATE_NORM;
      cnt_q <= '0;
    end else begin
      sel_q <= sel_d;
      cnt_q <= cnt_d;
    end
  end

  assign sel_o = sel_q;
  assign ce_o  = term;
endmodule

// File: rtl/crs_clk_rate_ctl.sv
module crs_clk_rate_ctl
  import crs_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int OVS       = 16,
  parameter int NORM_LOG2 = 2,
  parameter int PM1_LOG2  = 6,
  parameter int PM2_LOG2  = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rate_wr_i,
  input  logic [1:0]           rate_sel_i,
  input  logic                 sb_en_i,
  input  logic [NUM_PORTS-1:0] rx_i,
  input  logic                 os_tick_i,
  input  logic [NUM_PORTS-1:0] rx_done_i,
  input  logic [IRQ_W-1:0]     irq_act_i,
  output logic [1:0]           rate_sel_o,
  output logic                 clk_en_o,
  output logic [NUM_PORTS-1:0] start_ok_o,
  output logic [STAT_W-1:0]    status_o
);
  localparam int MID = OVS / 2;

  logic [1:0]           rst_pipe_q;
  logic                 rst_n_int;
  logic [NUM_PORTS-1:0] rx_sync;
  logic [NUM_PORTS-1:0] rx_fall;
  logic [NUM_PORTS-1:0] act;
  logic [SER_SLOT-1:0]  ser_act;
  logic                 sb_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  crs_rx_edge #(.NP(NUM_PORTS)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .rx_i      (rx_i),
    .rx_sync_o (rx_sync),
    .fall_o    (rx_fall)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    crs_start_check #(.MID_TICKS(MID)) u_sc (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .tick_i   (os_tick_i),
      .fall_i   (rx_fall[p]),
      .rx_i     (rx_sync[p]),
      .done_i   (rx_done_i[p]),
      .active_o (act[p]),
      .accept_o (start_ok_o[p])
    );
  end

  assign sb_fire = sb_en_i & (|rx_fall);

  crs_rate_gen #(
    .NORM_LOG2 (NORM_LOG2),
    .PM1_LOG2  (PM1_LOG2),
    .PM2_LOG2  (PM2_LOG2)
  ) u_rate (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en_i   (rate_wr_i),
    .wr_sel_i  (rate_sel_i),
    .sb_fire_i (sb_fire),
    .sel_o     (rate_sel_o),
    .ce_o      (clk_en_o)
  );

  if (NUM_PORTS < SER_SLOT) begin : g_pad
    assign ser_act = {{(SER_SLOT - NUM_PORTS){1'b0}}, act};
  end else begin : g_full
    assign ser_act = act;
  end

  assign status_o = {irq_act_i, ser_act};
endmodule

// File: rtl/crs_clk_rate_ctl_chk.sv
module crs_clk_rate_ctl_chk #(
  parameter int NP = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rate_wr_i,
  input logic          sb_en_i,
  input logic [NP-1:0] rx_fall,
  input logic [1:0]    rate_sel_o,
  input logic          clk_en_o,
  input logic [NP-1:0] start_ok_o,
  input logic [NP-1:0] act
);
  AST_SB_TO_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_en_i && (|rx_fall)) |=> (rate_sel_o == 2'b00)); // R4

  AST_NO_SELF_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rate_sel_o[1]) |-> $past(rate_wr_i)); // R8

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_wr_i && !(sb_en_i && (|rx_fall))) |=> $stable(rate_sel_o)); // R9

  AST_CE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_o |=> !clk_en_o); // R3

  AST_ACCEPT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_ok_o & ~act) == '0)); // R6

  AST_ACT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((act & ~$past(act) & ~$past(rx_fall)) == '0)); // R5
endmodule

bind crs_clk_rate_ctl crs_clk_rate_ctl_chk #(.NP(NUM_PORTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rate_wr_i  (rate_wr_i),
  .sb_en_i    (sb_en_i),
  .rx_fall    (rx_fall),
  .rate_sel_o (rate_sel_o),
  .clk_en_o   (clk_en_o),
  .start_ok_o (start_ok_o),
  .act        (status_o[NUM_PORTS-1:0])
);

// File: tb/crs_clk_rate_ctl_tb.sv
module crs_clk_rate_ctl_tb;
  logic       clk;
  logic       rst_n;
  logic       rate_wr_i;
  logic [1:0] rate_sel_i;
  logic       sb_en_i;
  logic [1:0] rx_i;
  logic       os_tick_i;
  logic [1:0] rx_done_i;
  logic [3:0] irq_act_i;
  logic [1:0] rate_sel_o;
  logic       clk_en_o;
  logic [1:0] start_ok_o;
  logic [7:0] status_o;

  int n_chk;
  int n_fail;

  crs_clk_rate_ctl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_wr_i  (rate_wr_i),
    .rate_sel_i (rate_sel_i),
    .sb_en_i    (sb_en_i),
    .rx_i       (rx_i),
    .os_tick_i  (os_tick_i),
    .rx_done_i  (rx_done_i),
    .irq_act_i  (irq_act_i),
    .rate_sel_o (rate_sel_o),
    .clk_en_o   (clk_en_o),
    .start_ok_o (start_ok_o),
    .status_o   (status_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // rate code in 13:12, expected clock-enable period in 11:0
  localparam logic [13:0] VEC [4] = '{
    {2'b10, 12'd64},
    {2'b01, 12'd4},
    {2'b11, 12'd1024},
    {2'b00, 12'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_rate(input logic [1:0] sel);
    rate_wr_i  = 1'b1;
    rate_sel_i = sel;
    @(negedge clk);
    rate_wr_i  = 1'b0;
  endtask

  task automatic get_period(output int per);
    per = 0;
    for (int i = 0; i < 3000 && !clk_en_o; i++) @(negedge clk);
    do begin
      @(negedge clk);
      per++;
    end while (!clk_en_o && per < 3000);
  endtask

  task automatic count_ok(input int n, input int port, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (start_ok_o[port]) c++;
    end
  endtask

  task automatic finish_rx(input int port);
    rx_i[port] = 1'b1;
    cyc(3);
    rx_done_i[port] = 1'b1;
    @(negedge clk);
    rx_done_i[port] = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    int per;
    int c;
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    rate_wr_i = 1'b0;
    rate_sel_i = 2'b00;
    sb_en_i = 1'b0;
    rx_i = 2'b11;
    os_tick_i = 1'b1;
    rx_done_i = 2'b00;
    irq_act_i = 4'b0000;
    cyc(5);

    // R1: reset state
    chk(rate_sel_o == 2'b00 && !clk_en_o && start_ok_o == 2'b00 && status_o[3:0] == 4'b0,
        "R1", int'({rate_sel_o, clk_en_o, start_ok_o, status_o[3:0]}), 0);
    rst_n = 1'b1;
    cyc(6);

    // R2/R3: table of rate codes and periods
    for (int i = 0; i < 4; i++) begin
      write_rate(VEC[i][13:12]);
      chk(rate_sel_o == VEC[i][13:12], "R2", int'(rate_sel_o), int'(VEC[i][13:12]));
      get_period(per);
      chk(per == int'(VEC[i][11:0]), "R3", per, int'(VEC[i][11:0]));
    end

    // R4/R5/R6: switchback on a valid start bit
    sb_en_i = 1'b1;
    write_rate(2'b11);
    rx_i[0] = 1'b0;
    cyc(3);
    chk(rate_sel_o == 2'b00, "R4", int'(rate_sel_o), 0);
    chk(status_o[0] == 1'b1, "R5", int'(status_o[0]), 1);
    count_ok(20, 0, c);
    chk(c == 1, "R6 accept", c, 1);
    chk(status_o[0] == 1'b1, "R6 held", int'(status_o[0]), 1);
    get_period(per);
    chk(per == 4, "R4 period", per, 4);
    finish_rx(0);
    chk(status_o[0] == 1'b0, "R6 done", int'(status_o[0]), 0);

    // R7/R8: glitch rejected, fast rate kept
    write_rate(2'b10);
    rx_i[1] = 1'b0;
    cyc(3);
    chk(rate_sel_o == 2'b00, "R4 port1", int'(rate_sel_o), 0);
    chk(status_o[1] == 1'b1, "R5 port1", int'(status_o[1]), 1);
    rx_i[1] = 1'b1;
    count_ok(20, 1, c);
    chk(c == 0, "R7 no accept", c, 0);
    chk(status_o[1] == 1'b0, "R7 activity", int'(status_o[1]), 0);
    chk(rate_sel_o == 2'b00, "R7 rate", int'(rate_sel_o), 0);
    cyc(300);
    chk(rate_sel_o == 2'b00, "R8", int'(rate_sel_o), 0);

    // R9: switchback disabled
    sb_en_i = 1'b0;
    write_rate(2'b11);
    rx_i[0] = 1'b0;
    cyc(3);
    chk(status_o[0] == 1'b1, "R5 sb off", int'(status_o[0]), 1);
    count_ok(20, 0, c);
    chk(rate_sel_o == 2'b11, "R9", int'(rate_sel_o), 3);

    // R12: edge while port 0 busy receiving
    sb_en_i = 1'b1;
    rx_i[0] = 1'b1;
    cyc(3);
    rx_i[0] = 1'b0;
    cyc(3);
    chk(rate_sel_o == 2'b00, "R12 switchback", int'(rate_sel_o), 0);
    count_ok(20, 0, c);
    chk(c == 0, "R12 no restart", c, 0);
    finish_rx(0);

    // R10: write collides with switchback edge
    write_rate(2'b11);
    rx_i[1] = 1'b0;
    cyc(2);
    rate_wr_i  = 1'b1;
    rate_sel_i = 2'b10;
    @(negedge clk);
    rate_wr_i  = 1'b0;
    chk(rate_sel_o == 2'b00, "R10", int'(rate_sel_o), 0);
    cyc(20);
    finish_rx(1);

    // R11: status layout
    irq_act_i = 4'b0110;
    @(negedge clk);
    chk(status_o == 8'b0110_0000, "R11 idle", int'(status_o), 8'h60);
    rx_i[0] = 1'b0;
    cyc(3);
    chk(status_o == 8'b0110_0001, "R11 active", int'(status_o), 8'h61);
    cyc(20);
    finish_rx(0);

    report();
    $finish;
  end
endmodule